// File: doc/BRIEF.md
# Ethernet Receive Frame Status Checker

This block sits beside a byte-wide receive stream coming from an MII-style front end and produces, for every frame, an 11-bit status word and a byte count. A frame is the run of cycles in which the data-valid input is high. The block runs a CRC-32 over every byte, counts bytes, and gathers error and condition inputs while the frame is in progress. On the first cycle in which data-valid is low again, it also samples a count of trailing stray bits.

On the clock edge that sees data-valid fall, the block compares the count against a programmable limit and against the untagged limit of 1518 bytes. It checks the CRC residue and combines the result with the sticky inputs. The finished status and count are registered and announced by a one-cycle valid pulse. Both stay on the outputs until the next frame ends. A descriptor engine downstream copies the word and the count into its receive descriptor.

Top module: `rx_frame_status`

## Requirements
- R1: The CRC is preset to all ones, uses reflected polynomial 0x04C11DB7 with data bit 0 first, and runs over data plus FCS. The CRC bit (status bit 3) is set when the register does not end at the residue 0xC704DD7B (0xDEBB20E3 in reflected order).
- R2: The CRC bit (status bit 3) is also set when `rx_err_i` is high in any cycle in which `rx_dv_i` is high during the frame.
- R3: The alignment bit (status bit 2) is set only when `dribble_i` is nonzero in the end cycle and the CRC bit is set. Stray bits on a frame with a good CRC leave it clear.
- R4: The oversize bit (status bit 10) is set when the byte count is greater than `max_len_i`. A count equal to `max_len_i` does not set it.
- R5: The untagged-oversize bit (status bit 5) is set when the byte count is greater than 1518 and `long_en_i` is low. It is never set while `long_en_i` is high.
- R6: The slow-link bit (status bit 8) equals `slow_link_i` as sampled with the first byte of the frame.
- R7: The overflow bit (status bit 4), parity bit (status bit 6) and halted bit (status bit 9) are set when `fifo_ovf_i`, `fifo_par_i` or `halted_i` respectively is high in any data cycle of the frame.
- R8: The good-completion bit (status bit 7) is set exactly when bits 10, 9, 6, 5, 4, 3 and 2 are all clear.
- R9: The byte count includes the four FCS bytes and saturates at 65535.
- R10: `status_valid_o` pulses for one cycle, one cycle after the first cycle in which `rx_dv_i` is low following a frame. Status and count hold until the next frame ends. After reset all outputs are zero.
- R11: Status bits 1 and 0 are reserved and always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_dv_i | input | 1 | Receive data valid, high for each frame byte |
| rx_data_i | input | 8 | Receive data byte |
| rx_err_i | input | 1 | Receive error from the PHY side |
| dribble_i | input | 3 | Stray bits past the last whole byte, valid in the end cycle |
| slow_link_i | input | 1 | High when the link runs at 10 Mb/s |
| max_len_i | input | 16 | Programmable maximum frame size in bytes |
| long_en_i | input | 1 | Long frames allowed; disables the untagged check |
| fifo_ovf_i | input | 1 | Receive FIFO overflow indication |
| fifo_par_i | input | 1 | Receive FIFO parity error indication |
| halted_i | input | 1 | Reception halted indication |
| status_valid_o | output | 1 | One-cycle pulse when status is updated |
| status_o | output | 11 | Frame status word, bit 10 down to bit 0 |
| byte_cnt_o | output | 16 | Received byte count including FCS |

## Verification
The CRC path is driven with correct FCS frames, frames with a flipped FCS bit, and frames with a mid-frame receive error. Each of these is run with and without stray bits, which separates the alignment bit from the CRC bit in both directions. Lengths sit one byte either side of the programmable limit and of 1518, with long frames off and on. One frame longer than 65535 bytes shows the count saturating while the CRC still passes. Single-cycle pulses on the overflow, parity, halted and slow-link inputs show that each reaches only its own bit and clears the good-completion bit where it should.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int ST_W        = 11;
  localparam int ST_OVERSIZE = 10;
  localparam int ST_HALTED   = 9;
  localparam int ST_SLOW     = 8;
  localparam int ST_OK       = 7;
  localparam int ST_PARITY   = 6;
  localparam int ST_UNTAG    = 5;
  localparam int ST_OVF      = 4;
  localparam int ST_CRC      = 3;
  localparam int ST_ALIGN    = 2;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3; // 0xC704DD7B bit-reversed

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxs_crc.sv
module rxs_crc
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              crc_ok_o
);
  logic [31:0] crc_q, crc_base;

  assign crc_base = start_i ? CRC_PRESET : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_PRESET;
    else if (en_i) crc_q <= crc_step(crc_base, data_i);
  end

  assign crc_ok_o = (crc_q == CRC_RESIDUE);

  // R1
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_q));
endmodule

// File: rtl/rxs_len.sv
module rxs_len #(
  parameter int CNT_W     = 16,
  parameter int UNTAG_MAX = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] max_len_i,
  input  logic             long_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             oversize_o,
  output logic             untag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] UNTAG_LIM = CNT_W'(UNTAG_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (en_i && start_i)   cnt_q <= CNT_W'(1);
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign oversize_o = cnt_q > max_len_i;
  assign untag_o    = !long_en_i && (cnt_q > UNTAG_LIM);

  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !start_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  // R9
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !start_i && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  input  logic err_i,
  input  logic ovf_i,
  input  logic par_i,
  input  logic halt_i,
  input  logic slow_i,
  output logic err_o,
  output logic ovf_o,
  output logic par_o,
  output logic halt_o,
  output logic slow_o
);
  logic [3:0] sticky_q, sticky_in;
  logic       slow_q;

  assign sticky_in = {err_i, ovf_i, par_i, halt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      slow_q   <= 1'b0;
    end else if (en_i) begin
      sticky_q <= start_i ? sticky_in : (sticky_q | sticky_in);
      if (start_i) slow_q <= slow_i;
    end
  end

  assign {err_o, ovf_o, par_o, halt_o} = sticky_q;
  assign slow_o = slow_q;

  // R2
  err_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && err_i |=> err_o);
  // R7
  ovf_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !start_i && ovf_o |=> ovf_o);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DRIB_W    = 3,
  parameter int CNT_W     = 16,
  parameter int UNTAG_MAX = 1518
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_dv_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  input  logic [DRIB_W-1:0] dribble_i,
  input  logic              slow_link_i,
  input  logic [CNT_W-1:0]  max_len_i,
  input  logic              long_en_i,
  input  logic              fifo_ovf_i,
  input  logic              fifo_par_i,
  input  logic              halted_i,
  output logic              status_valid_o,
  output logic [ST_W-1:0]   status_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  logic dv_q, start, frame_end;
  logic crc_ok, oversize, untag;
  logic err_s, ovf_s, par_s, halt_s, slow_s;
  logic [CNT_W-1:0] cnt;
  logic [ST_W-1:0]  st_d;
  logic             crc_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dv_q <= 1'b0;
    else         dv_q <= rx_dv_i;
  end

  assign start     = rx_dv_i && !dv_q;
  assign frame_end = dv_q && !rx_dv_i;

  rxs_crc #(.DATA_W(DATA_W)) u_crc (
    .clk_i, .rst_ni, .start_i(start), .en_i(rx_dv_i),
    .data_i(rx_data_i), .crc_ok_o(crc_ok)
  );

  rxs_len #(.CNT_W(CNT_W), .UNTAG_MAX(UNTAG_MAX)) u_len (
    .clk_i, .rst_ni, .start_i(start), .en_i(rx_dv_i),
    .max_len_i, .long_en_i, .cnt_o(cnt),
    .oversize_o(oversize), .untag_o(untag)
  );

  rxs_flags u_flags (
    .clk_i, .rst_ni, .start_i(start), .en_i(rx_dv_i),
    .err_i(rx_err_i), .ovf_i(fifo_ovf_i), .par_i(fifo_par_i),
    .halt_i(halted_i), .slow_i(slow_link_i),
    .err_o(err_s), .ovf_o(ovf_s), .par_o(par_s),
    .halt_o(halt_s), .slow_o(slow_s)
  );

  assign crc_bad = !crc_ok || err_s;

  always_comb begin
    st_d              = '0;
    st_d[ST_OVERSIZE] = oversize;
    st_d[ST_HALTED]   = halt_s;
    st_d[ST_SLOW]     = slow_s;
    st_d[ST_PARITY]   = par_s;
    st_d[ST_UNTAG]    = untag;
    st_d[ST_OVF]      = ovf_s;
    st_d[ST_CRC]      = crc_bad;
    st_d[ST_ALIGN]    = crc_bad && (|dribble_i);
    st_d[ST_OK]       = !(oversize || halt_s || par_s || untag || ovf_s || st_d[ST_CRC] || st_d[ST_ALIGN]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_valid_o <= 1'b0;
      status_o       <= '0;
      byte_cnt_o     <= '0;
    end else begin
      status_valid_o <= frame_end;
      if (frame_end) begin
        status_o   <= st_d;
        byte_cnt_o <= cnt;
      end
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |=> !status_valid_o);
  // R10
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(status_o) && $stable(byte_cnt_o));
  // R3
  align_needs_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_ALIGN] |-> status_o[ST_CRC]);
  // R8
  ok_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_OK] |-> !status_o[ST_OVERSIZE] && !status_o[ST_HALTED] && status_o[6:2] == 5'b0);
  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1:0] == 2'b00);
endmodule

// File: tb/tb_rx_frame_status.sv
module tb_rx_frame_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_dv_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_err_i = 1'b0;
  logic [2:0]  dribble_i = '0;
  logic        slow_link_i = 1'b0;
  logic [15:0] max_len_i = 16'hFFFF;
  logic        long_en_i = 1'b0;
  logic        fifo_ovf_i = 1'b0;
  logic        fifo_par_i = 1'b0;
  logic        halted_i = 1'b0;
  logic        status_valid_o;
  logic [10:0] status_o;
  logic [15:0] byte_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rx_frame_status dut (.*);

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Sends n payload bytes plus FCS; side inputs pulse once at byte 2.
  task automatic run_frame(input string name, input int n, input bit bad_fcs, input int err_at,
                           input int drib, input bit slow, input bit ovf, input bit par,
                           input bit hlt, input int mx, input bit lng);
    logic [31:0] crc = 32'hFFFFFFFF;
    logic [31:0] fcs;
    logic [10:0] st_exp;
    int total = n + 4;
    int cnt_exp;
    bit crc_e, ov_e, un_e, al_e;
    max_len_i = 16'(mx);
    long_en_i = lng;
    for (int i = 0; i < total; i++) begin
      @(negedge clk_i);
      rx_dv_i     = 1'b1;
      slow_link_i = (i == 0) ? slow : ~slow;
      rx_err_i    = (i == err_at);
      fifo_ovf_i  = ovf && (i == 2);
      fifo_par_i  = par && (i == 2);
      halted_i    = hlt && (i == 2);
      if (i < n) begin
        rx_data_i = 8'(i * 7 + n);
        crc = ref_crc(crc, rx_data_i);
        if (i == n - 1) fcs = ~crc;
      end else begin
        rx_data_i = fcs[8*(i-n) +: 8];
        if (bad_fcs && i == n) rx_data_i[0] = ~rx_data_i[0];
      end
    end
    @(negedge clk_i);
    rx_dv_i = 1'b0; rx_err_i = 1'b0; fifo_ovf_i = 1'b0; fifo_par_i = 1'b0;
    halted_i = 1'b0; slow_link_i = 1'b0; rx_data_i = '0;
    dribble_i = 3'(drib);
    @(negedge clk_i);
    dribble_i = '0;
    cnt_exp = (total > 65535) ? 65535 : total;
    crc_e = bad_fcs || (err_at >= 0 && err_at < total);
    ov_e  = cnt_exp > mx;
    un_e  = !lng && cnt_exp > 1518;
    al_e  = crc_e && drib != 0;
    st_exp = '0;
    st_exp[10] = ov_e; st_exp[9] = hlt; st_exp[8] = slow; st_exp[6] = par;
    st_exp[5] = un_e; st_exp[4] = ovf; st_exp[3] = crc_e; st_exp[2] = al_e;
    st_exp[7] = !(ov_e || hlt || par || un_e || ovf || crc_e || al_e);
    $display("frame %s", name);
    chk("R10 valid pulse", status_valid_o, 1);
    chk("R1 R2 crc bit", status_o[3], st_exp[3]);
    chk("R3 align bit", status_o[2], st_exp[2]);
    chk("R4 oversize bit", status_o[10], st_exp[10]);
    chk("R5 untagged bit", status_o[5], st_exp[5]);
    chk("R6 slow bit", status_o[8], st_exp[8]);
    chk("R7 ovf/par/halt bits", {status_o[9], status_o[6], status_o[4]}, {st_exp[9], st_exp[6], st_exp[4]});
    chk("R8 ok bit", status_o[7], st_exp[7]);
    chk("R11 reserved", status_o[1:0], 0);
    chk("R9 byte count", byte_cnt_o, cnt_exp);
    @(negedge clk_i);
    chk("R10 pulse ends", status_valid_o, 0);
    chk("R10 status held", {status_o, byte_cnt_o}, {st_exp, 16'(cnt_exp)});
  endtask

  task automatic t_reset();
    chk("R10 reset valid", status_valid_o, 0);
    chk("R10 reset status", status_o, 0);
    chk("R10 reset count", byte_cnt_o, 0);
  endtask

  task automatic t_crc();
    run_frame("good",         60, 0, -1, 0, 0, 0, 0, 0, 65535, 0); // R1 R8
    run_frame("bad fcs",      60, 1, -1, 0, 0, 0, 0, 0, 65535, 0); // R1
    run_frame("bad fcs drib", 61, 1, -1, 3, 0, 0, 0, 0, 65535, 0); // R3
    run_frame("good drib",    62, 0, -1, 5, 0, 0, 0, 0, 65535, 0); // R3
    run_frame("rx err",       60, 0, 10, 0, 0, 0, 0, 0, 65535, 0); // R2
    run_frame("rx err fcs",   60, 0, 62, 1, 0, 0, 0, 0, 65535, 0); // R2 R3
  endtask

  task automatic t_length();
    run_frame("at max",     96, 0, -1, 0, 0, 0, 0, 0, 100, 0);  // R4
    run_frame("over max",   97, 0, -1, 0, 0, 0, 0, 0, 100, 0);  // R4
    run_frame("1518",     1514, 0, -1, 0, 0, 0, 0, 0, 65535, 0); // R5
    run_frame("1519",     1515, 0, -1, 0, 0, 0, 0, 0, 65535, 0); // R5
    run_frame("1519 long",1515, 0, -1, 0, 0, 0, 0, 0, 65535, 1); // R5
  endtask

  task automatic t_side();
    run_frame("slow",   64, 0, -1, 0, 1, 0, 0, 0, 65535, 0); // R6
    run_frame("ovf",    64, 0, -1, 0, 0, 1, 0, 0, 65535, 0); // R7
    run_frame("par",    64, 0, -1, 0, 0, 0, 1, 0, 65535, 0); // R7
    run_frame("halt",   64, 0, -1, 0, 0, 0, 0, 1, 65535, 0); // R7 R8
  endtask

  task automatic t_saturate();
    run_frame("saturate", 65540, 0, -1, 0, 0, 0, 0, 0, 65535, 1); // R9
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_crc();
    t_length();
    t_side();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule